// File: doc/BRIEF.md
# Serial-Bus Byte-Memory Slave with Page Commit

This block is the target side of a two-wire serial bus (I2C) in front of a 256-byte memory. The memory stands in for a nonvolatile array and uses a simulated programming time. A bus master selects the device with a 7-bit device address. On a write, the master sends a one-byte word address and then up to a page of data bytes. These bytes are collected in a 16-entry page buffer and are only written to the array after the stop condition that closes the transfer. On a read, the block returns bytes starting at the current pointer and advances the pointer after each byte.

After a write is committed, the block enters a busy window that lasts `BUSY_CYCLES` clock cycles. During that window it ignores the bus completely, so a master that polls the device address sees no acknowledge. Two inputs can stop a commit: a write-protect level and a supply-low inhibit. Both are sampled at the stop. A blocked write is still acknowledged byte by byte, but nothing reaches the array and no busy window starts.

The protocol engine is one state machine. Its states are:
- IDLE: waiting for a start condition.
- DEV: shifting in the device byte.
- DEV_ACK: acknowledging the device byte.
- ADDR: shifting in the word address.
- ADDR_ACK: acknowledging the word address.
- WDATA: shifting in a data byte.
- WDATA_ACK: acknowledging a data byte.
- RDATA: shifting out a data byte.
- RDATA_ACK: sampling the master's acknowledge.
- SKIP: not addressed or finished; waiting for the next start or stop.

Its transitions are:
- start, from any state, goes to DEV.
- stop, from any state, goes to IDLE.
- In DEV, a completed byte goes to DEV_ACK if the address matches, and to SKIP if it does not.
- DEV_ACK goes to RDATA when the read/write bit is 1 and to ADDR when it is 0.
- ADDR goes to ADDR_ACK, and ADDR_ACK goes to WDATA.
- WDATA and WDATA_ACK alternate.
- RDATA goes to RDATA_ACK. RDATA_ACK goes back to RDATA on a master acknowledge and to SKIP on a NACK.
- While busy, the state is held in IDLE.

Top module: `eep_i2c_slave`

## Requirements
- R1: After reset the block does not pull SDA, and every memory byte reads 0xFF (erased).
- R2: A device byte whose upper seven bits equal binary 1010 followed by the parameter `DEV_SEL` is acknowledged on the ninth clock. The least significant bit is the read/write flag, with 1 meaning read. Any other device byte gets no acknowledge.
- R3: The word address byte is always acknowledged and becomes the memory pointer.
- R4: Each write data byte is acknowledged. Data bytes take effect in the array only after the stop that ends the write.
- R5: During a write, the pointer advances only in its low four bits. Bytes past the 16th wrap within the same 16-byte page and overwrite earlier bytes of that transfer.
- R6: A read returns the byte at the pointer and increments the pointer after every byte, wrapping from 0xFF to 0x00. A master acknowledge continues the read and a NACK ends it. A later current-address read continues from the incremented pointer.
- R7: For `BUSY_CYCLES` cycles after a committing stop, the block acknowledges nothing and never pulls SDA.
- R8: If write-protect is high at the stop, the write is acknowledged but not committed, and no busy window follows.
- R9: If the supply-low inhibit is high at the stop, the write is acknowledged but not committed, and no busy window follows.
- R10: A repeated start returns to device-address reception, which allows a word-address-only write followed by a read. A write with no data bytes commits nothing and starts no busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bus lines are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired value) |
| wp_i | input | 1 | Write protect, high blocks commits |
| supply_low_i | input | 1 | Supply-low inhibit, high blocks commits |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain drive) |

## Verification
The hardest situation to reach from the ports is the busy window. It must be entered from a real stop after buffered data, and then probed with an address attempt before the window closes. The bench therefore issues the address probe directly after the committing stop. It then waits out the window and reads back the page. Page wrap is reached the same way, with an 18-byte burst that starts near the end of a page. The expected contents come from a byte-level model in the bench.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_SKIP
    } eep_state_e;
endpackage

// File: rtl/eep_bus_edges.sv
module eep_bus_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  = !scl_q && scl_i;
    assign scl_fall  = scl_q && !scl_i;
    assign start_det = scl_q && scl_i && sda_q && !sda_i;
    assign stop_det  = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int ENTRIES = 16,
    parameter int DW      = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       we,
    input  logic [$clog2(ENTRIES)-1:0] wr_off,
    input  logic [DW-1:0]              wr_data,
    input  logic [$clog2(ENTRIES)-1:0] rd_off,
    output logic [DW-1:0]              rd_data,
    output logic                       rd_valid,
    output logic                       any_valid
);
    localparam int OW = $clog2(ENTRIES);

    logic [DW-1:0]      data_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[g]  <= '0;
                valid_q[g] <= 1'b0;
            end else if (clr) begin
                valid_q[g] <= 1'b0;
            end else if (we && (wr_off == OW'(g))) begin
                data_q[g]  <= wr_data;
                valid_q[g] <= 1'b1;
            end
        end
    end

    assign rd_data   = data_q[rd_off];
    assign rd_valid  = valid_q[rd_off];
    assign any_valid = |valid_q;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int            DEPTH  = 256,
    parameter int            DW     = 8,
    parameter logic [DW-1:0] ERASED = '1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED;
            rdata <= ERASED;
        end else begin
            if (we) cells[waddr] <= wdata;
            rdata <= cells[raddr];
        end
    end
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
    import eep_pkg::*;
#(
    parameter logic [2:0] DEV_SEL     = 3'b000,
    parameter int         MEM_DEPTH   = 256,
    parameter int         PAGE_BYTES  = 16,
    parameter int         BUSY_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    input  logic supply_low_i,
    output logic sda_pull_o
);
    localparam int AW = $clog2(MEM_DEPTH);
    localparam int OW = $clog2(PAGE_BYTES);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic scl_rise, scl_fall, start_det, stop_det;
    eep_state_e state, state_d;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg, tx;
    logic              rw_q, nack_q;
    logic [AW-1:0]     ptr;
    logic [CW-1:0]     busy_cnt;
    logic              busy;
    logic              commit_on;
    logic [OW-1:0]     commit_idx;
    logic              byte_done, rx_state, ack_state, dev_match, commit_ok;
    logic              buf_we, buf_clr, buf_valid, buf_any;
    logic [BYTE_W-1:0] buf_rdata, mem_rdata;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr;

    eep_bus_edges u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign busy      = (busy_cnt != '0);
    assign byte_done = scl_fall && (bitcnt == 4'd8);
    assign rx_state  = (state == ST_DEV) || (state == ST_ADDR) || (state == ST_WDATA);
    assign ack_state = (state == ST_DEV_ACK) || (state == ST_ADDR_ACK) ||
                       (state == ST_WDATA_ACK) || (state == ST_RDATA_ACK);
    assign dev_match = (shreg[7:1] == {4'b1010, DEV_SEL});
    assign commit_ok = !busy && stop_det && buf_any && !wp_i && !supply_low_i &&
                       ((state == ST_WDATA) || (state == ST_WDATA_ACK));

    assign buf_we    = !busy && byte_done && (state == ST_WDATA);
    assign buf_clr   = !busy && byte_done && (state == ST_ADDR);
    assign mem_we    = commit_on && buf_valid;
    assign mem_waddr = {ptr[AW-1:OW], commit_idx};

    eep_page_buf #(
        .ENTRIES (PAGE_BYTES),
        .DW      (BYTE_W)
    ) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .we        (buf_we),
        .wr_off    (ptr[OW-1:0]),
        .wr_data   (shreg),
        .rd_off    (commit_idx),
        .rd_data   (buf_rdata),
        .rd_valid  (buf_valid),
        .any_valid (buf_any)
    );

    eep_array #(
        .DEPTH (MEM_DEPTH),
        .DW    (BYTE_W)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (buf_rdata),
        .raddr (ptr),
        .rdata (mem_rdata)
    );

    // Next-state logic
    always_comb begin
        state_d = state;
        if (busy || stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_DEV;
        end else begin
            unique case (state)
                ST_IDLE:      state_d = ST_IDLE;
                ST_DEV:       if (byte_done) state_d = dev_match ? ST_DEV_ACK : ST_SKIP;
                ST_DEV_ACK:   if (scl_fall)  state_d = rw_q ? ST_RDATA : ST_ADDR;
                ST_ADDR:      if (byte_done) state_d = ST_ADDR_ACK;
                ST_ADDR_ACK:  if (scl_fall)  state_d = ST_WDATA;
                ST_WDATA:     if (byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  state_d = ST_WDATA;
                ST_RDATA:     if (byte_done) state_d = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall)  state_d = nack_q ? ST_SKIP : ST_RDATA;
                ST_SKIP:      state_d = ST_SKIP;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Datapath, pointer, busy window and commit sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt     <= '0;
            shreg      <= '0;
            tx         <= '0;
            rw_q       <= 1'b0;
            nack_q     <= 1'b0;
            ptr        <= '0;
            busy_cnt   <= '0;
            commit_on  <= 1'b0;
            commit_idx <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt - CW'(1);
            if (commit_on) begin
                commit_idx <= commit_idx + OW'(1);
                if (commit_idx == OW'(PAGE_BYTES - 1)) commit_on <= 1'b0;
            end
        end else if (commit_ok) begin
            busy_cnt   <= CW'(BUSY_CYCLES);
            commit_on  <= 1'b1;
            commit_idx <= '0;
        end else if (start_det) begin
            bitcnt <= '0;
        end else begin
            if (scl_rise && rx_state && (bitcnt != 4'd8)) begin
                shreg  <= {shreg[6:0], sda_i};
                bitcnt <= bitcnt + 4'd1;
            end
            if (scl_rise && (state == ST_RDATA) && (bitcnt != 4'd8))
                bitcnt <= bitcnt + 4'd1;
            if (scl_fall && (state == ST_RDATA) && (bitcnt != 4'd8))
                tx <= {tx[6:0], 1'b0};
            if (scl_rise && (state == ST_RDATA_ACK))
                nack_q <= sda_i;
            if (byte_done) begin
                unique case (state)
                    ST_DEV:   rw_q <= shreg[0];
                    ST_ADDR:  ptr <= shreg[AW-1:0];
                    ST_WDATA: ptr[OW-1:0] <= ptr[OW-1:0] + OW'(1);
                    ST_RDATA: ptr <= ptr + AW'(1);
                    default:  ;
                endcase
            end
            if (scl_fall && ack_state) bitcnt <= '0;
            if (scl_fall && (state == ST_DEV_ACK) && rw_q) tx <= mem_rdata;
            if (scl_fall && (state == ST_RDATA_ACK) && !nack_q) tx <= mem_rdata;
        end
    end

    // Output logic
    always_comb begin
        sda_pull_o = 1'b0;
        unique case (state)
            ST_DEV_ACK, ST_ADDR_ACK, ST_WDATA_ACK: sda_pull_o = 1'b1;
            ST_RDATA:                              sda_pull_o = !tx[7];
            default:                               sda_pull_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/eep_i2c_slave_chk.sv
module eep_i2c_slave_chk
    import eep_pkg::*;
#(
    parameter int         AW      = 8,
    parameter int         OW      = 4,
    parameter logic [2:0] DEV_SEL = 3'b000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              sda_pull_o,
    input logic              stop_det,
    input logic              wp_i,
    input logic              supply_low_i,
    input logic              mem_we,
    input eep_state_e        state,
    input logic [AW-1:0]     ptr,
    input logic [BYTE_W-1:0] shreg
);
    p_quiet_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull_o);

    p_write_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    p_window_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

    p_protect_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wp_i));

    p_inhibit_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(supply_low_i));

    p_page_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA_ACK) |-> (ptr[AW-1:OW] == $past(ptr[AW-1:OW])));

    p_ack_on_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ACK) |-> (shreg[7:1] == {4'b1010, DEV_SEL}));
endmodule

bind eep_i2c_slave eep_i2c_slave_chk #(
    .AW      (AW),
    .OW      (OW),
    .DEV_SEL (DEV_SEL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .sda_pull_o   (sda_pull_o),
    .stop_det     (stop_det),
    .wp_i         (wp_i),
    .supply_low_i (supply_low_i),
    .mem_we       (mem_we),
    .state        (state),
    .ptr          (ptr),
    .shreg        (shreg)
);

// File: tb/eep_i2c_slave_test.sv
module eep_i2c_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 5;
    localparam int BUSY       = 400;
    localparam logic [2:0] SEL = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic slow = 1'b0;
    logic sda_pull;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] model [256];
    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD / 2) clk = !clk;
    assign sda_line = sda_m & !sda_pull;

    eep_i2c_slave #(
        .DEV_SEL     (SEL),
        .MEM_DEPTH   (256),
        .PAGE_BYTES  (16),
        .BUSY_CYCLES (BUSY)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda_line),
        .wp_i         (wp),
        .supply_low_i (slow),
        .sda_pull_o   (sda_pull)
    );

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Scoreboard monitor: compares read bytes against expected bytes
    always @(negedge clk) begin
        if (exp_q.size() > 0 && got_q.size() > 0) begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic logic [7:0] g = got_q.pop_front();
            automatic string      t = tag_q.pop_front();
            check(t, int'(g), int'(e));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wbit(input logic b);
        sda_m = b; tick(Q);
        scl = 1'b1; tick(2 * Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b);
        ack = !b;
    endtask

    task automatic rbyte(input logic mack, output logic [7:0] d);
        logic b;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            rbit(b);
            d = {d[6:0], b};
        end
        wbit(!mack);
    endtask

    function automatic logic [7:0] devb(input logic [2:0] sel, input logic rd);
        return {4'b1010, sel, rd};
    endfunction

    task automatic do_write(input logic [7:0] addr, input logic [7:0] data[$], input string tag);
        logic ack;
        bus_start();
        wbyte(devb(SEL, 1'b0), ack); check({tag, " dev ack"}, ack, 1);
        wbyte(addr, ack);            check({tag, " R3 addr ack"}, ack, 1);
        foreach (data[i]) begin
            wbyte(data[i], ack);
            check({tag, " R4 data ack"}, ack, 1);
        end
        bus_stop();
        if (!wp && !slow) begin
            foreach (data[i])
                model[{addr[7:4], 4'(addr[3:0] + 4'(i))}] = data[i];
        end
    endtask

    task automatic read_bytes(input int n, input logic [7:0] first, input string tag);
        logic [7:0] d;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(model[8'(first + 8'(i))]);
            tag_q.push_back(tag);
            rbyte(i < n - 1, d);
            got_q.push_back(d);
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] addr, input int n, input string tag);
        logic ack;
        bus_start();
        wbyte(devb(SEL, 1'b0), ack); check({tag, " R10 dev ack"}, ack, 1);
        wbyte(addr, ack);            check({tag, " R3 addr ack"}, ack, 1);
        bus_start();
        wbyte(devb(SEL, 1'b1), ack); check({tag, " R10 restart read ack"}, ack, 1);
        read_bytes(n, addr, tag);
    endtask

    task automatic probe(input int exp_ack, input string tag);
        logic ack;
        bus_start();
        wbyte(devb(SEL, 1'b0), ack);
        check(tag, ack, exp_ack);
        bus_stop();
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] d[$];
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        check("R1 SDA released after reset", sda_pull, 0);
        do_read(8'h00, 1, "R1 erased read");

        // R4 buffered write, R7 busy window
        d = {8'h11, 8'h22, 8'h33};
        do_write(8'h20, d, "R4 write");
        probe(0, "R7 no ack while busy");
        tick(BUSY + 20);
        probe(1, "R7 ack after window");
        do_read(8'h20, 3, "R4 readback");

        // R2 wrong device address
        bus_start();
        wbyte(devb(3'b000, 1'b0), ack);
        check("R2 foreign address not acked", ack, 0);
        bus_stop();

        // R5 page wrap with 18 bytes
        d = {};
        for (int i = 0; i < 18; i++) d.push_back(8'(8'h40 + i));
        do_write(8'h3E, d, "R5 burst");
        tick(BUSY + 20);
        do_read(8'h30, 16, "R5 page contents");

        // R6 sequential read across 0xFF to 0x00 and current-address read
        d = {8'hA1, 8'hA2};
        do_write(8'hFE, d, "R6 top");
        tick(BUSY + 20);
        d = {8'hC5, 8'hD6};
        do_write(8'h00, d, "R6 bottom");
        tick(BUSY + 20);
        do_read(8'hFE, 3, "R6 wrap read");
        bus_start();
        wbyte(devb(SEL, 1'b1), ack);
        check("R6 current read ack", ack, 1);
        read_bytes(1, 8'h01, "R6 current address");

        // R8 write protect
        wp = 1'b1;
        d = {8'hEE};
        do_write(8'h20, d, "R8 protected");
        probe(1, "R8 no busy after protected write");
        wp = 1'b0;
        do_read(8'h20, 1, "R8 unchanged");

        // R9 supply inhibit
        slow = 1'b1;
        d = {8'h5A};
        do_write(8'h21, d, "R9 inhibited");
        probe(1, "R9 no busy after inhibited write");
        slow = 1'b0;
        do_read(8'h21, 1, "R9 unchanged");

        // R10 address-only write starts no busy window
        d = {};
        do_write(8'h22, d, "R10 address only");
        probe(1, "R10 no busy after address only");

        tick(20);
        check("R6 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule